// File: doc/BRIEF.md
# Six-Channel Tick-Driven Timer Bank

This block holds six independent 32-bit up-counting timers behind a simple bus. Each access takes one cycle: a write lands on the next rising clock edge, and a read returns data combinationally in the cycle the address is driven. Each timer has four words: a control word (enable, counter clear, run mode), a clock-setup word (tick source and divider), a live counter and a compare value. Timers are numbered 1 to 6. Address slot 0 holds the shared interrupt-enable register and the write-one-to-clear acknowledge register.

Timers do not count bus clocks. They count single-cycle strobes, synchronous to the bus clock, from one of two tick inputs: a fast system tick or a slow 32 kHz tick. A divide-by-two option can be applied to the selected strobe. Three run modes are available. One-shot stops at the compare value. Repeat reloads to zero at the compare value and keeps running. Free-running wraps at 2^32 and acts as a monotonic timebase. A compare hit in one-shot or repeat mode sets the timer's pending flag. That flag is masked by its enable bit to drive the timer's interrupt line, and the six lines are ORed onto one combined request.

Top module: `gptm_bank`

## Requirements
- R1: Register map for timer n (n = 1..6). The control word is at byte 0x10·n, clock setup at 0x10·n+4, counter at 0x10·n+8 and compare at 0x10·n+0xC. Interrupt enable is at 0x00. Writes to 0x08 acknowledge, and reads of 0x08 return the pending flags. Timer n uses bit n−1 of both shared registers. Other slot-0 words read 0, and every register reads 0 after reset.
- R2: Clock-setup bit 4 selects the slow tick when 1 and the fast tick when 0. Bits [3:0] hold the divider code. Code 1 advances the counter on every second selected strobe, and every other code advances it on every selected strobe.
- R3: While control bit 0 (enable) is 1, each effective tick raises the counter by one. While enable is 0 the counter holds. The counter can be written and can be read back live.
- R4: Control bits [5:4] select the run mode. Codes 0 and 2 are one-shot: the tick that brings the counter to the compare value sets the pending flag and clears enable, and the counter then stays at the compare value.
- R5: Mode code 1 is repeat: the tick that would bring the counter to the compare value sets the pending flag instead, loads the counter with 0, and leaves the timer enabled.
- R6: Mode code 3 is free-running: the counter wraps from 0xFFFFFFFF to 0 and never sets the pending flag, even when it equals the compare value.
- R7: Writing control with bit 1 set loads the counter with 0 and restarts the divide-by-two phase. Bit 1 always reads back as 0.
- R8: Interrupt line n−1 equals pending flag n ANDed with enable bit n−1. The combined request is the OR of the six lines.
- R9: Writing 1 to acknowledge bit n−1 clears pending flag n and leaves the other flags unchanged. A compare hit in the same cycle keeps the flag set. Writing 0x3F clears every flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tick_fast | input | 1 | Fast system tick strobe, one cycle wide |
| tick_slow | input | 1 | Slow 32 kHz tick strobe, one cycle wide |
| tmr_irq | output | 6 | Masked pending flag of each timer |
| irq | output | 1 | OR of all timer interrupt lines |

## Verification
A register write takes effect at the rising edge during which it is presented, so a read in the following cycle returns the new value. A tick strobe sampled at a rising edge updates the counter and the pending flag at that same edge, and the interrupt lines follow combinationally. The bench therefore drives each write, tick or combined stimulus on a falling edge, lets exactly one rising edge pass, and samples outputs and read data on the next falling edge. The same-cycle acknowledge and compare hit is produced by raising the acknowledge write and the tick strobe in one cycle.

// File: rtl/gptm_pkg.sv
`timescale 1ns/1ps
package gptm_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 32;
    localparam int DIV_W  = 4;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;
    localparam int CLK_SRC_BIT   = 4;

    localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(1);

    typedef enum logic [1:0] {
        RUN_ONCE   = 2'd0,
        RUN_REPEAT = 2'd1,
        RUN_SPARE  = 2'd2,
        RUN_FREE   = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        WD_CTRL = 2'd0,
        WD_CLK  = 2'd1,
        WD_CNT  = 2'd2,
        WD_CMP  = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic              ctrl_we;
        logic              clk_we;
        logic              cnt_we;
        logic              cmp_we;
        logic [DATA_W-1:0] data;
    } chan_wr_t;

    typedef struct packed {
        logic              en;
        run_mode_e         mode;
        logic              slow;
        logic [DIV_W-1:0]  div;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
    } chan_view_t;

    function automatic logic [DATA_W-1:0] ctrl_word(input chan_view_t v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_EN_BIT] = v.en;
        w[CTRL_MODE_LSB +: 2] = v.mode;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] clk_word(input chan_view_t v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DIV_W-1:0] = v.div;
        w[CLK_SRC_BIT] = v.slow;
        return w;
    endfunction

    function automatic logic mode_stops(input run_mode_e m);
        return (m != RUN_REPEAT) && (m != RUN_FREE);
    endfunction

endpackage

// File: rtl/gptm_tick_sel.sv
`timescale 1ns/1ps
module gptm_tick_sel
    import gptm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             use_slow,
    input  logic [DIV_W-1:0] div_code,
    input  logic             run,
    input  logic             restart,
    output logic             step
);

    logic src_tick;
    logic halve;
    logic phase_q;

    assign src_tick = use_slow ? tick_slow : tick_fast;
    assign halve    = (div_code == DIV_HALF);
    assign step     = run && src_tick && (!halve || phase_q);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= 1'b0;
        end else if (run && src_tick && halve) begin
            phase_q <= ~phase_q;
        end
    end

    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(phase_q)) else $error("phase moved while idle"); // R2

endmodule

// File: rtl/gptm_channel.sv
`timescale 1ns/1ps
module gptm_channel
    import gptm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_wr_t   wr,
    input  logic       ack,
    input  logic       tick_fast,
    input  logic       tick_slow,
    output chan_view_t view,
    output logic       pend
);

    logic             en_q;
    run_mode_e        mode_q;
    logic             slow_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             pend_q;

    logic             hold;
    logic             restart;
    logic             step;
    logic             hit;
    logic [CNT_W-1:0] cnt_inc;

    // A control or counter write in the same cycle as a tick takes precedence.
    assign hold    = wr.ctrl_we || wr.cnt_we;
    assign restart = wr.ctrl_we && wr.data[CTRL_CLR_BIT];
    assign cnt_inc = cnt_q + CNT_W'(1);
    assign hit     = step && (cnt_inc == cmp_q) && (mode_q != RUN_FREE);

    gptm_tick_sel u_tick (
        .clk       (clk),
        .rst       (rst),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .use_slow  (slow_q),
        .div_code  (div_q),
        .run       (en_q && !hold),
        .restart   (restart),
        .step      (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mode_q <= RUN_ONCE;
        end else if (wr.ctrl_we) begin
            en_q   <= wr.data[CTRL_EN_BIT];
            mode_q <= run_mode_e'(wr.data[CTRL_MODE_LSB +: 2]);
        end else if (hit && mode_stops(mode_q)) begin
            en_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr.cnt_we) begin
            cnt_q <= wr.data[CNT_W-1:0];
        end else if (restart) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (hit && mode_q == RUN_REPEAT) ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slow_q <= 1'b0;
            div_q  <= '0;
            cmp_q  <= '0;
        end else begin
            if (wr.clk_we) begin
                slow_q <= wr.data[CLK_SRC_BIT];
                div_q  <= wr.data[DIV_W-1:0];
            end
            if (wr.cmp_we) begin
                cmp_q <= wr.data[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (ack) begin
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        view.en   = en_q;
        view.mode = mode_q;
        view.slow = slow_q;
        view.div  = div_q;
        view.cnt  = cnt_q;
        view.cmp  = cmp_q;
    end
    assign pend = pend_q;

    AST_ONCE_HALT: assert property (@(posedge clk) disable iff (rst)
        (hit && mode_stops(mode_q)) |=> (!en_q && pend_q && cnt_q == cmp_q)) else $error("one-shot did not stop"); // R4
    AST_RPT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (hit && mode_q == RUN_REPEAT) |=> (cnt_q == '0 && en_q && pend_q)) else $error("repeat did not reload"); // R5
    AST_FREE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> ($past(mode_q) != RUN_FREE)) else $error("free-run raised pending"); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (restart && !wr.cnt_we) |=> (cnt_q == '0)) else $error("clear left counter nonzero"); // R7
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> !pend_q) else $error("ack did not clear"); // R9
    AST_MATCH_WINS: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend_q) else $error("hit lost to ack"); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !wr.cnt_we && !wr.ctrl_we) |=> $stable(cnt_q)) else $error("disabled counter moved"); // R3

endmodule

// File: rtl/gptm_regif.sv
`timescale 1ns/1ps
module gptm_regif
    import gptm_pkg::*;
#(
    parameter int NT     = 6,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  chan_view_t [NT-1:0]     views,
    input  logic [NT-1:0]           pend,
    output chan_wr_t [NT-1:0]       chan_wr,
    output logic [NT-1:0]           ack,
    output logic [NT-1:0]           ien,
    output logic [DATA_W-1:0]       bus_rdata
);

    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    word_sel_e         word;
    logic              wr_go;
    logic              shared;
    logic [NT-1:0]     ien_q;

    assign slot   = bus_addr[ADDR_W-1:4];
    assign word   = word_sel_e'(bus_addr[3:2]);
    assign wr_go  = bus_en && bus_we;
    assign shared = (slot == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (wr_go && shared && word == WD_CTRL) begin
            ien_q <= bus_wdata[NT-1:0];
        end
    end
    assign ien = ien_q;

    assign ack = (wr_go && shared && word == WD_CNT) ? bus_wdata[NT-1:0] : '0;

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            logic sel;
            sel = wr_go && (slot == SLOT_W'(i + 1));
            chan_wr[i].ctrl_we = sel && (word == WD_CTRL);
            chan_wr[i].clk_we  = sel && (word == WD_CLK);
            chan_wr[i].cnt_we  = sel && (word == WD_CNT);
            chan_wr[i].cmp_we  = sel && (word == WD_CMP);
            chan_wr[i].data    = bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (shared) begin
            if (word == WD_CTRL) bus_rdata = DATA_W'(ien_q);
            else if (word == WD_CNT) bus_rdata = DATA_W'(pend);
        end
        for (int i = 0; i < NT; i++) begin
            if (slot == SLOT_W'(i + 1)) begin
                case (word)
                    WD_CTRL: bus_rdata = ctrl_word(views[i]);
                    WD_CLK:  bus_rdata = clk_word(views[i]);
                    WD_CNT:  bus_rdata = DATA_W'(views[i].cnt);
                    default: bus_rdata = DATA_W'(views[i].cmp);
                endcase
            end
        end
    end

    AST_IEN_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(wr_go && shared && word == WD_CTRL) |=> $stable(ien_q)) else $error("enable changed without write"); // R8

endmodule

// File: rtl/gptm_bank.sv
`timescale 1ns/1ps
module gptm_bank
    import gptm_pkg::*;
#(
    parameter int NT     = 6,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic [NT-1:0]     tmr_irq,
    output logic              irq
);

    chan_wr_t   [NT-1:0] chan_wr;
    chan_view_t [NT-1:0] views;
    logic       [NT-1:0] pend;
    logic       [NT-1:0] ack;
    logic       [NT-1:0] ien;

    gptm_regif #(.NT(NT), .ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .views     (views),
        .pend      (pend),
        .chan_wr   (chan_wr),
        .ack       (ack),
        .ien       (ien),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NT; g++) begin : g_chan
        gptm_channel u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr        (chan_wr[g]),
            .ack       (ack[g]),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .view      (views[g]),
            .pend      (pend[g])
        );
    end

    assign tmr_irq = pend & ien;
    assign irq     = |tmr_irq;

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ((pend & ien) != '0 && ($past(ien) != ien || $past(pend) != pend))) else $error("irq rose without cause"); // R8

endmodule

// File: tb/gptm_bank_tb_top.sv
`timescale 1ns/1ps
module gptm_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic [5:0]  tmr_irq;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gptm_bank dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fast(tick_fast), .tick_slow(tick_slow),
        .tmr_irq(tmr_irq), .irq(irq)
    );

    function automatic logic [7:0] a_ctl(input int n); return 8'(16 * n);     endfunction
    function automatic logic [7:0] a_clk(input int n); return 8'(16 * n + 4); endfunction
    function automatic logic [7:0] a_cnt(input int n); return 8'(16 * n + 8); endfunction
    function automatic logic [7:0] a_cmp(input int n); return 8'(16 * n + 12); endfunction
    localparam logic [7:0] A_IEN = 8'h00;
    localparam logic [7:0] A_ACK = 8'h08;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic check_rd(input string req, input string what, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
        check(req, what, d, exp);
    endtask

    task automatic pulse(input bit slow, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
            @(negedge clk);
            tick_slow = 1'b0; tick_fast = 1'b0;
        end
    endtask

    task automatic t_reset();
        check_rd("R1", "ctrl1 after reset", a_ctl(1), 32'h0);
        check_rd("R1", "clk6 after reset", a_clk(6), 32'h0);
        check_rd("R1", "cnt1 after reset", a_cnt(1), 32'h0);
        check_rd("R1", "cmp3 after reset", a_cmp(3), 32'h0);
        check_rd("R1", "ien after reset", A_IEN, 32'h0);
        check_rd("R1", "pending after reset", A_ACK, 32'h0);
        check("R8", "irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_oneshot();
        wr(a_clk(1), 32'h0);
        wr(a_cmp(1), 32'd3);
        wr(A_IEN, 32'h01);
        wr(a_ctl(1), 32'h01);
        check_rd("R1", "cmp1 readback", a_cmp(1), 32'd3);
        check_rd("R1", "ien readback", A_IEN, 32'h01);
        pulse(1'b0, 2);
        check_rd("R3", "cnt1 after 2 ticks", a_cnt(1), 32'd2);
        check("R8", "irq before hit", {31'b0, irq}, 32'h0);
        pulse(1'b0, 1);
        check("R8", "tmr_irq on one-shot hit", {26'b0, tmr_irq}, 32'h01);
        check("R8", "irq on one-shot hit", {31'b0, irq}, 32'h1);
        check_rd("R4", "cnt1 at hit", a_cnt(1), 32'd3);
        check_rd("R4", "ctrl1 enable cleared", a_ctl(1), 32'h00);
        check_rd("R4", "pending after hit", A_ACK, 32'h01);
        pulse(1'b0, 2);
        check_rd("R4", "cnt1 holds after stop", a_cnt(1), 32'd3);
        wr(A_ACK, 32'h01);
        check("R9", "irq after ack", {31'b0, irq}, 32'h0);
        check_rd("R9", "pending after ack", A_ACK, 32'h00);
    endtask

    task automatic t_repeat();
        wr(a_cmp(2), 32'd2);
        wr(a_ctl(2), 32'h11);
        pulse(1'b0, 1);
        check_rd("R5", "cnt2 after 1 tick", a_cnt(2), 32'd1);
        check_rd("R5", "no pending before hit", A_ACK, 32'h00);
        pulse(1'b0, 1);
        check_rd("R5", "cnt2 reloaded", a_cnt(2), 32'd0);
        check_rd("R5", "pending on repeat hit", A_ACK, 32'h02);
        check_rd("R5", "ctrl2 still enabled", a_ctl(2), 32'h11);
        check("R8", "masked timer2 line", {26'b0, tmr_irq}, 32'h00);
        check_rd("R3", "disabled cnt1 holds", a_cnt(1), 32'd3);
        wr(A_ACK, 32'h02);
        pulse(1'b0, 2);
        check_rd("R5", "second period pending", A_ACK, 32'h02);
        check_rd("R5", "cnt2 reloaded again", a_cnt(2), 32'd0);
        wr(A_ACK, 32'h02);
        pulse(1'b0, 1);
        // acknowledge and hit presented in one cycle
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h02; tick_fast = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; tick_fast = 1'b0;
        check_rd("R9", "hit wins over same-cycle ack", A_ACK, 32'h02);
        wr(a_ctl(2), 32'h10);
        wr(A_ACK, 32'h02);
        check_rd("R9", "pending cleared", A_ACK, 32'h00);
    endtask

    task automatic t_free();
        wr(a_cnt(3), 32'hFFFF_FFFE);
        wr(a_cmp(3), 32'hFFFF_FFFF);
        wr(a_ctl(3), 32'h31);
        check_rd("R3", "cnt3 write readback", a_cnt(3), 32'hFFFF_FFFE);
        pulse(1'b0, 1);
        check_rd("R6", "cnt3 reaches compare", a_cnt(3), 32'hFFFF_FFFF);
        check_rd("R6", "no pending at compare", A_ACK, 32'h00);
        pulse(1'b0, 1);
        check_rd("R6", "cnt3 wraps", a_cnt(3), 32'h0);
        check_rd("R6", "still no pending", A_ACK, 32'h00);
    endtask

    task automatic t_div2();
        wr(a_clk(4), 32'h11);
        wr(a_ctl(4), 32'h31);
        check_rd("R1", "clk4 readback", a_clk(4), 32'h11);
        pulse(1'b0, 3);
        check_rd("R2", "fast ticks ignored on slow source", a_cnt(4), 32'd0);
        pulse(1'b1, 1);
        check_rd("R2", "first slow tick halved", a_cnt(4), 32'd0);
        pulse(1'b1, 1);
        check_rd("R2", "second slow tick counts", a_cnt(4), 32'd1);
        pulse(1'b1, 2);
        check_rd("R2", "four slow ticks give 2", a_cnt(4), 32'd2);
        pulse(1'b1, 1);
        wr(a_ctl(4), 32'h33);
        check_rd("R7", "clear zeroes cnt4", a_cnt(4), 32'd0);
        check_rd("R7", "clear bit reads 0", a_ctl(4), 32'h31);
        pulse(1'b1, 1);
        check_rd("R7", "phase restarted", a_cnt(4), 32'd0);
        pulse(1'b1, 1);
        check_rd("R7", "counts after phase restart", a_cnt(4), 32'd1);
    endtask

    task automatic t_divcode();
        wr(a_clk(5), 32'h02);
        wr(a_ctl(5), 32'h31);
        pulse(1'b0, 3);
        check_rd("R2", "unused divider code is divide-by-1", a_cnt(5), 32'd3);
        check_rd("R6", "free-run cnt3 keeps counting", a_cnt(3), 32'd6);
        wr(a_ctl(3), 32'h33);
        check_rd("R7", "clear zeroes cnt3", a_cnt(3), 32'd0);
        check_rd("R7", "ctrl3 readback", a_ctl(3), 32'h31);
    endtask

    task automatic t_mask_ack();
        wr(a_cmp(6), 32'd1);
        wr(a_ctl(6), 32'h01);
        pulse(1'b0, 1);
        check_rd("R4", "timer6 pending", A_ACK, 32'h20);
        check_rd("R4", "ctrl6 stopped", a_ctl(6), 32'h00);
        check("R8", "masked line stays low", {26'b0, tmr_irq}, 32'h00);
        check("R8", "masked irq stays low", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h21);
        check("R8", "unmasked line", {26'b0, tmr_irq}, 32'h20);
        check("R8", "unmasked irq", {31'b0, irq}, 32'h1);
        wr(A_ACK, 32'h01);
        check_rd("R9", "other ack bit leaves flag", A_ACK, 32'h20);
        wr(A_ACK, 32'h3F);
        check_rd("R9", "ack-all clears", A_ACK, 32'h00);
        check("R9", "irq after ack-all", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_oneshot();
        t_repeat();
        t_free();
        t_div2();
        t_divcode();
        t_mask_ack();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule